// File: doc/BRIEF.md
# Integer ALU with Shifts

This block is the integer arithmetic-logic unit of a small load/store processor core. Each cycle it takes two 32-bit operands, a 5-bit shift count and a 4-bit operation code. It computes one of nine operations. The result and a zero flag are captured in an output register and appear one clock cycle later.

The nine operations are:
- wrapping add and subtract;
- bitwise AND, OR and NOR;
- signed set-on-less-than, which returns the word 0 or 1;
- logical left and right shifts of operand B by the separate shift count;
- upper-half placement of a 16-bit immediate.

Branch logic uses the zero flag after a subtract to decide equal or not-equal. Operation codes with no assigned operation produce a zero word.

Internally, a decoder turns the operation code into a small set of select strobes. A datapath holds:
- one shared adder for add, subtract and compare;
- a logarithmic shifter;
- an AND-OR result selector.

Top module: `int_alu`

## Requirements
- R1: With opSel = 0 (add), one cycle later result equals operandA + operandB modulo 2^32.
- R2: With opSel = 1 (subtract), one cycle later result equals operandA - operandB modulo 2^32.
- R3: opSel = 2 gives A AND B, opSel = 3 gives A OR B, opSel = 4 gives NOT (A OR B), all bitwise.
- R4: With opSel = 5 (set-less-than), result is 1 when operandA < operandB as signed two's complement and 0 otherwise. This holds even when A - B overflows, and bits 31:1 are always zero.
- R5: With opSel = 6, result is operandB shifted left by shamt (0..31), with zeros shifted into the low bits.
- R6: With opSel = 7, result is operandB shifted right by shamt (0..31), with zeros shifted into the high bits.
- R7: With opSel = 8, result bits 31:16 equal operandB[15:0] and bits 15:0 are zero.
- R8: The zero output is 1 exactly when the result output is all zeros.
- R9: opSel values 9 to 15 produce result 0, whatever the operands and shamt are.
- R10: Outputs change only on a rising clock edge, one cycle after the inputs are sampled. While rstN is low, result is 0 and zero is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| opSel | input | 4 | Operation code (see R1 to R9) |
| operandA | input | 32 | First operand |
| operandB | input | 32 | Second operand; also the shift source and the immediate source |
| shamt | input | 5 | Shift count for opSel 6 and 7 |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered flag: result is all zeros |

## Verification
The sweep covers several cases:
- **Signed compare at the extremes.** It pairs 0x80000000 and 0x7FFFFFFF in both orders, where A - B overflows. A compare that uses only the sign of the difference returns the inverted answer there.
- **Shift counts 0, 1, 15 and 31 on every operation, plus all 32 counts on a mixed pattern.** A shifter stage wired to the wrong count bit, or one that fills with ones, shows up as a wrong word at specific counts.
- **Wraparound of add and subtract at 0xFFFFFFFF.** This pairs with the zero flag on results that wrap exactly to zero.
- **Every unused operation code.** A decoder that falls through to another operation leaks a nonzero word.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_NOR = 4'd4,
    OP_SLT = 4'd5,
    OP_SHL = 4'd6,
    OP_SHR = 4'd7,
    OP_UPR = 4'd8
  } aluOp_e;

  // Strobes from decode to datapath; at most one pick* is active.
  typedef struct packed {
    logic invertB;
    logic pickSum;
    logic pickAnd;
    logic pickOr;
    logic pickNor;
    logic pickLess;
    logic pickShl;
    logic pickShr;
    logic pickUpper;
  } aluStrobes_t;
endpackage

// File: rtl/alu_control.sv
`timescale 1ns/1ps
module alu_control
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluStrobes_t     strobes
);
  always_comb begin
    strobes = '0;
    case (opSel)
      OP_ADD: strobes.pickSum = 1'b1;
      OP_SUB: begin strobes.pickSum = 1'b1; strobes.invertB = 1'b1; end
      OP_AND: strobes.pickAnd = 1'b1;
      OP_OR:  strobes.pickOr  = 1'b1;
      OP_NOR: strobes.pickNor = 1'b1;
      OP_SLT: begin strobes.pickLess = 1'b1; strobes.invertB = 1'b1; end
      OP_SHL: strobes.pickShl = 1'b1;
      OP_SHR: strobes.pickShr = 1'b1;
      OP_UPR: strobes.pickUpper = 1'b1;
      default: strobes = '0;
    endcase
  end

  // R9: unused codes select nothing; decoded codes select exactly one source
  always_comb begin
    assert_one_source_R9: assert ($onehot0({strobes.pickSum, strobes.pickAnd, strobes.pickOr,
        strobes.pickNor, strobes.pickLess, strobes.pickShl, strobes.pickShr, strobes.pickUpper}));
  end
endmodule

// File: rtl/alu_datapath.sv
`timescale 1ns/1ps
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [SHAMT_W-1:0] shiftBy,
  input  aluStrobes_t        strobes,
  output logic [DATA_W-1:0]  aluOut,
  output logic               isZero
);
  localparam int MSB  = DATA_W - 1;
  localparam int HALF = DATA_W / 2;

  // Shared adder: subtract and compare use A + ~B + 1
  logic [DATA_W-1:0] bEff, sum;
  logic overflow, lessThan;
  assign bEff     = opB ^ {DATA_W{strobes.invertB}};
  assign sum      = opA + bEff + DATA_W'(strobes.invertB);
  assign overflow = (opA[MSB] == bEff[MSB]) && (sum[MSB] != opA[MSB]);
  assign lessThan = sum[MSB] ^ overflow;

  // Logarithmic shifters, one stage per shift-count bit
  logic [DATA_W-1:0] lStage [0:SHAMT_W];
  logic [DATA_W-1:0] rStage [0:SHAMT_W];
  assign lStage[0] = opB;
  assign rStage[0] = opB;
  for (genvar g = 0; g < SHAMT_W; g++) begin : gShift
    assign lStage[g+1] = shiftBy[g] ? (lStage[g] << (2**g)) : lStage[g];
    assign rStage[g+1] = shiftBy[g] ? (rStage[g] >> (2**g)) : rStage[g];
  end

  logic [DATA_W-1:0] upperWord;
  assign upperWord = {opB[HALF-1:0], {HALF{1'b0}}};

  // AND-OR selector: an unselected term contributes zero
  always_comb begin
    aluOut = ({DATA_W{strobes.pickSum}}   & sum)
           | ({DATA_W{strobes.pickAnd}}   & (opA & opB))
           | ({DATA_W{strobes.pickOr}}    & (opA | opB))
           | ({DATA_W{strobes.pickNor}}   & ~(opA | opB))
           | ({DATA_W{strobes.pickLess}}  & DATA_W'(lessThan))
           | ({DATA_W{strobes.pickShl}}   & lStage[SHAMT_W])
           | ({DATA_W{strobes.pickShr}}   & rStage[SHAMT_W])
           | ({DATA_W{strobes.pickUpper}} & upperWord);
  end
  assign isZero = (aluOut == '0);

  // R4: a compare never produces a value above one
  always_comb begin
    if (strobes.pickLess) assert_slt_word_R4: assert (aluOut[MSB:1] == '0);
  end
endmodule

// File: rtl/int_alu.sv
`timescale 1ns/1ps
module int_alu
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [OP_W-1:0]     opSel,
  input  logic [DATA_W-1:0]   operandA,
  input  logic [DATA_W-1:0]   operandB,
  input  logic [SHAMT_W-1:0]  shamt,
  output logic [DATA_W-1:0]   result,
  output logic                zero
);
  localparam int HALF = DATA_W / 2;

  aluStrobes_t strobes;
  logic [DATA_W-1:0] aluOut;
  logic isZero;

  alu_control u_control (.opSel(opSel), .strobes(strobes));

  alu_datapath #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_datapath (
    .opA(operandA), .opB(operandB), .shiftBy(shamt),
    .strobes(strobes), .aluOut(aluOut), .isZero(isZero)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      zero   <= 1'b1;
    end else begin
      result <= aluOut;
      zero   <= isZero;
    end
  end

  // Marks that the output register holds a computed value
  logic primed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    zero == (result == '0));

  assert_add_R1: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(opSel) == OP_ADD) |-> result == $past(operandA) + $past(operandB));

  assert_sub_R2: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(opSel) == OP_SUB) |-> result == $past(operandA) - $past(operandB));

  assert_upper_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(opSel) == OP_UPR) |-> result[HALF-1:0] == '0);

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(opSel) > OP_UPR) |-> (result == '0 && zero));
endmodule

// File: tb/int_alu_tb.sv
`timescale 1ns/1ps
module int_alu_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0]  opSel = '0;
  logic [31:0] operandA = '0, operandB = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        zero;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  int_alu u_dut (.clk(clk), .rstN(rstN), .opSel(opSel), .operandA(operandA),
                 .operandB(operandB), .shamt(shamt), .result(result), .zero(zero));

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] sh);
    case (op)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return ~(a | b);
      4'd5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd6: return b << sh;
      4'd7: return b >> sh;
      4'd8: return {b[15:0], 16'h0000};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] pattern(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'hA532_8D7E;
      6: return 32'h0000_FFFF;
      default: return 32'h1234_5678;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Drive on a falling edge, let one rising edge capture, sample at the next falling edge
  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh);
    logic [31:0] exp;
    opSel = op; operandA = a; operandB = b; shamt = sh;
    exp = model(op, a, b, sh);
    @(posedge clk);
    @(negedge clk);
    check(reqOf(op), result, exp);
    check("R8", 32'(zero), 32'(exp == 32'd0));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R10: reset state, with an active operation presented during reset
    opSel = 4'd0; operandA = 32'd5; operandB = 32'd7;
    repeat (3) @(negedge clk);
    check("R10", result, 32'd0);
    check("R10", 32'(zero), 32'd1);
    rstN = 1'b1;
    @(negedge clk);

    // Directed corners
    apply(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);   // R4: overflowing compare, expect 1
    apply(4'd5, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);   // R4: expect 0
    apply(4'd1, 32'h1234_5678, 32'h1234_5678, 5'd0);   // R2 and R8: equal operands
    apply(4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);   // R1: wrap to zero
    apply(4'd8, 32'hFFFF_FFFF, 32'hDEAD_A532, 5'd31);  // R7

    // R10: the output holds between rising edges after the inputs change
    apply(4'd3, 32'h0F0F_0000, 32'h0000_00F0, 5'd0);
    opSel = 4'd4; operandA = 32'h0; operandB = 32'h0;
    #1;
    check("R10", result, 32'h0F0F_00F0);
    @(negedge clk);
    check("R10", result, 32'hFFFF_FFFF);

    // Sweep: every code, operand pairs, selected shift counts
    for (int op = 0; op < 16; op++)
      for (int ai = 0; ai < 8; ai++)
        for (int bi = 0; bi < 8; bi++)
          for (int si = 0; si < 4; si++) begin
            logic [4:0] sh;
            sh = (si == 0) ? 5'd0 : (si == 1) ? 5'd1 : (si == 2) ? 5'd15 : 5'd31;
            apply(4'(op), pattern(ai), pattern(bi), sh);
          end

    // R5 and R6: every shift count on a mixed pattern
    for (int s = 0; s < 32; s++) begin
      apply(4'd6, 32'hFFFF_FFFF, 32'hA532_8D7E, 5'(s));
      apply(4'd7, 32'hFFFF_FFFF, 32'hA532_8D7E, 5'(s));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule